// File: doc/BRIEF.md
# SD card bring-up sequencer

This block takes a freshly powered SD card to the ready state without software help. On a start pulse it drives a simple command-path request interface through a fixed series of commands:

- a software reset of the card;
- a voltage and echo probe that tells a high-capacity card from a standard one;
- a loop of application-prefix command plus operating-conditions command, repeated until the card reports that its power-up has finished.

Between loop passes it stays quiet for a programmable number of clock cycles. It gives up with an error after a bounded number of not-ready answers. Every response is judged, and the first bad one ends the run with an error.

The command path beneath it serialises each request onto the card line. It returns one completion pulse per command, carrying four status flags and the 32-bit short response. When the run finishes, the sequencer presents these results until the next start:

- a done or an error indication;
- the probe's capacity verdict;
- the capacity bit of the final operating-conditions word;
- the whole final operating-conditions word.

Top module: `card_init_seq`

## Requirements
- R1: After reset `cmd_valid`, `done` and `err` are 0 and no command is issued until `start`. A `start` pulse is taken only when idle, done or failed. A `start` while a run is in progress has no effect on the command sequence or the result.
- R2: A request is presented with `cmd_valid` = 1. `cmd_idx`, `cmd_arg` and `cmd_rsp_exp` stay stable until the cycle in which `cmd_done` is 1. Exactly one completion finishes one command.
- R3: The first command is index 0 with argument 0 and `cmd_rsp_exp` = 0. Unless its completion carries `st_sent` = 1, the run ends with `err` = 1 and no further command is issued.
- R4: The second command is index 8 with argument 0x000001AA and `cmd_rsp_exp` = 1. `high_cap` becomes 1 only if the completion has `st_rsp_end` or `st_crc_bad` set, `st_timeout` clear, and `rsp_word[11:0]` = 0x1AA. A timeout or a mismatching echo gives `high_cap` = 0, and the run continues either way.
- R5: Each loop pass starts with index 55, argument 0, `cmd_rsp_exp` = 1. It is accepted only if (`st_rsp_end` or `st_crc_bad`) is set, `st_timeout` is clear and `rsp_word[5]` = 1. Otherwise the run ends with `err` = 1.
- R6: The second command of a pass is index 41, `cmd_rsp_exp` = 1. Its argument is 0x40FF8000 when `high_cap` = 1 and 0x00800000 when `high_cap` = 0.
- R7: A completion of index 41 is accepted as a response when `st_rsp_end` or `st_crc_bad` is set and `st_timeout` is clear. Otherwise the run ends with `err` = 1.
- R8: An accepted index-41 response with `rsp_word[31]` = 1 ends the run with `done` = 1. It latches `ocr_word` = `rsp_word` and `high_cap_conf` = `rsp_word[30]`.
- R9: An accepted index-41 response with `rsp_word[31]` = 0 holds `cmd_valid` low for exactly max(`gap_len`, MIN_GAP) cycles, then starts a new pass with index 55.
- R10: The MAX_TRIES-th not-ready index-41 response ends the run with `err` = 1 at once, with no further wait or command.
- R11: `done` and `err` are never both 1, and they hold with the result outputs until the next accepted `start`. An accepted `start` clears `done`, `err`, `high_cap`, `high_cap_conf` and `ocr_word` to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card-side clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up run (pulse) |
| gap_len | input | GAP_W | Requested wait between loop passes, in cycles; floored at MIN_GAP |
| cmd_valid | output | 1 | Command request present |
| cmd_idx | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_exp | output | 1 | Command expects a short response |
| cmd_done | input | 1 | Command completion pulse |
| st_sent | input | 1 | Completion: command sent (no-response commands) |
| st_rsp_end | input | 1 | Completion: response received with good CRC |
| st_crc_bad | input | 1 | Completion: response received with bad CRC |
| st_timeout | input | 1 | Completion: no response within the card's limit |
| rsp_word | input | 32 | Short response payload |
| done | output | 1 | Card reached ready |
| err | output | 1 | Run ended with a failure |
| high_cap | output | 1 | Probe identified a high-capacity card |
| high_cap_conf | output | 1 | Capacity bit of the final operating-conditions word |
| ocr_word | output | 32 | Final operating-conditions word |

## Verification
The assertions take for granted that the command path raises `cmd_done` only while `cmd_valid` is high, for a single cycle per command. They also take for granted that the status flags and `rsp_word` mean something only in that completion cycle. The bench's responder model keeps within these rules. It waits a fixed latency after each new request, raises `cmd_done` once, and drops it before looking at the next request. It never sets a timeout together with a received-response flag. Start pulses are driven away from the clock edge. One of them is deliberately placed mid-run, where the design must ignore it.

// File: rtl/card_init_pkg.sv
package card_init_pkg;

    localparam int IDX_W = 6;
    localparam int WORD_W = 32;

    localparam logic [IDX_W-1:0] IX_RESET  = 6'd0;
    localparam logic [IDX_W-1:0] IX_PROBE  = 6'd8;
    localparam logic [IDX_W-1:0] IX_APP    = 6'd55;
    localparam logic [IDX_W-1:0] IX_OPCOND = 6'd41;

    localparam logic [WORD_W-1:0] PROBE_ARG   = 32'h0000_01AA;
    localparam logic [11:0]       PROBE_ECHO  = 12'h1AA;
    localparam logic [WORD_W-1:0] OPC_ARG_HC  = 32'h40FF_8000;
    localparam logic [WORD_W-1:0] OPC_ARG_STD = 32'h0080_0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_PROBE,
        ST_APP,
        ST_OPCOND,
        ST_GAP,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    typedef struct packed {
        logic fail;
        logic echo_ok;
        logic ready;
    } verdict_t;

    typedef struct packed {
        seq_state_e        state;
        logic              hc;
        logic              hc_conf;
        logic [WORD_W-1:0] ocr;
    } seq_regs_t;

endpackage

// File: rtl/card_resp_eval.sv
module card_resp_eval
    import card_init_pkg::*;
(
    input  seq_state_e state,
    input  logic       st_sent,
    input  logic       st_rsp_end,
    input  logic       st_crc_bad,
    input  logic       st_timeout,
    input  logic [11:0] echo_bits,
    input  logic       bit_app,
    input  logic       bit_ready,
    output verdict_t   verdict
);

    logic got_rsp;

    always_comb begin
        // a bad CRC still counts as a received word; a timeout never does
        got_rsp = (st_rsp_end | st_crc_bad) & ~st_timeout;
        verdict = '0;
        case (state)
            ST_RESET:  verdict.fail    = ~st_sent;
            ST_PROBE:  verdict.echo_ok = got_rsp & (echo_bits == PROBE_ECHO);
            ST_APP:    verdict.fail    = ~(got_rsp & bit_app);
            ST_OPCOND: begin
                verdict.fail  = ~got_rsp;
                verdict.ready = got_rsp & bit_ready;
            end
            default:   verdict = '0;
        endcase
    end

endmodule

// File: rtl/card_gap_timer.sv
module card_gap_timer #(
    parameter int GAP_W   = 16,
    parameter int MIN_GAP = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] gap_len,
    output logic             expired
);

    localparam logic [GAP_W-1:0] MIN_LEN = GAP_W'(MIN_GAP);

    logic [GAP_W-1:0] len_eff;
    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        len_eff = (gap_len < MIN_LEN) ? MIN_LEN : gap_len;
        cnt_d   = cnt_q;
        if (load) begin
            cnt_d = len_eff - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
        expired = (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R9: once loaded the wait drains one cycle at a time
    assert_gap_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/card_try_counter.sv
module card_try_counter #(
    parameter int MAX_TRIES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);

    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] LAST = TRY_W'(MAX_TRIES - 1);

    logic [TRY_W-1:0] cnt_d, cnt_q;

    always_comb begin
        exhausted = inc && (cnt_q == LAST);
        cnt_d     = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !exhausted) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R10: the pass count never runs past its limit
    assert_try_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < TRY_W'(MAX_TRIES));

endmodule

// File: rtl/card_init_seq.sv
module card_init_seq
    import card_init_pkg::*;
#(
    parameter int GAP_W     = 16,
    parameter int MIN_GAP   = 1000,
    parameter int MAX_TRIES = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [GAP_W-1:0] gap_len,
    output logic             cmd_valid,
    output logic [5:0]       cmd_idx,
    output logic [31:0]      cmd_arg,
    output logic             cmd_rsp_exp,
    input  logic             cmd_done,
    input  logic             st_sent,
    input  logic             st_rsp_end,
    input  logic             st_crc_bad,
    input  logic             st_timeout,
    input  logic [31:0]      rsp_word,
    output logic             done,
    output logic             err,
    output logic             high_cap,
    output logic             high_cap_conf,
    output logic [31:0]      ocr_word
);

    seq_regs_t r_d, r_q;
    verdict_t  verdict;
    logic      gap_load, gap_expired;
    logic      try_clr, try_inc, try_exhausted;

    card_resp_eval u_eval (
        .state      (r_q.state),
        .st_sent    (st_sent),
        .st_rsp_end (st_rsp_end),
        .st_crc_bad (st_crc_bad),
        .st_timeout (st_timeout),
        .echo_bits  (rsp_word[11:0]),
        .bit_app    (rsp_word[5]),
        .bit_ready  (rsp_word[31]),
        .verdict    (verdict)
    );

    card_gap_timer #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (gap_load),
        .gap_len (gap_len),
        .expired (gap_expired)
    );

    card_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (try_clr),
        .inc       (try_inc),
        .exhausted (try_exhausted)
    );

    always_comb begin
        r_d      = r_q;
        gap_load = 1'b0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        case (r_q.state)
            ST_IDLE, ST_DONE, ST_FAIL: begin
                if (start) begin
                    r_d.state   = ST_RESET;
                    r_d.hc      = 1'b0;
                    r_d.hc_conf = 1'b0;
                    r_d.ocr     = '0;
                    try_clr     = 1'b1;
                end
            end
            ST_RESET: begin
                if (cmd_done) begin
                    r_d.state = verdict.fail ? ST_FAIL : ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (cmd_done) begin
                    r_d.hc    = verdict.echo_ok;
                    r_d.state = ST_APP;
                end
            end
            ST_APP: begin
                if (cmd_done) begin
                    r_d.state = verdict.fail ? ST_FAIL : ST_OPCOND;
                end
            end
            ST_OPCOND: begin
                if (cmd_done) begin
                    if (verdict.fail) begin
                        r_d.state = ST_FAIL;
                    end else if (verdict.ready) begin
                        r_d.state   = ST_DONE;
                        r_d.ocr     = rsp_word;
                        r_d.hc_conf = rsp_word[30];
                    end else begin
                        try_inc = 1'b1;
                        if (try_exhausted) begin
                            r_d.state = ST_FAIL;
                        end else begin
                            r_d.state = ST_GAP;
                            gap_load  = 1'b1;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (gap_expired) begin
                    r_d.state = ST_APP;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, hc: 1'b0, hc_conf: 1'b0, ocr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        cmd_valid   = 1'b0;
        cmd_idx     = '0;
        cmd_arg     = '0;
        cmd_rsp_exp = 1'b0;
        case (r_q.state)
            ST_RESET: begin
                cmd_valid = 1'b1;
                cmd_idx   = IX_RESET;
            end
            ST_PROBE: begin
                cmd_valid   = 1'b1;
                cmd_idx     = IX_PROBE;
                cmd_arg     = PROBE_ARG;
                cmd_rsp_exp = 1'b1;
            end
            ST_APP: begin
                cmd_valid   = 1'b1;
                cmd_idx     = IX_APP;
                cmd_rsp_exp = 1'b1;
            end
            ST_OPCOND: begin
                cmd_valid   = 1'b1;
                cmd_idx     = IX_OPCOND;
                cmd_arg     = r_q.hc ? OPC_ARG_HC : OPC_ARG_STD;
                cmd_rsp_exp = 1'b1;
            end
            default: cmd_valid = 1'b0;
        endcase
    end

    assign done          = (r_q.state == ST_DONE);
    assign err           = (r_q.state == ST_FAIL);
    assign high_cap      = r_q.hc;
    assign high_cap_conf = r_q.hc_conf;
    assign ocr_word      = r_q.ocr;

    // R2: a pending request keeps its fields until completed
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done) |=>
            (cmd_valid && $stable(cmd_idx) && $stable(cmd_arg) && $stable(cmd_rsp_exp)));

    // R11: a finished result holds while no start arrives
    assert_result_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || err) && !start) |=>
            ($stable(done) && $stable(err) && $stable(ocr_word) &&
             $stable(high_cap) && $stable(high_cap_conf)));

    // R8: a ready result always carries the power-up bit in its word
    assert_ready_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ocr_word[31]);

    // R1: a start during a run leaves the request untouched
    assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_done && start) |=> (cmd_valid && $stable(cmd_idx)));

endmodule

// File: tb/card_init_seq_bench.sv
`timescale 1ns/1ps
module card_init_seq_bench;

    localparam int GAP_W     = 16;
    localparam int MIN_GAP   = 20;
    localparam int MAX_TRIES = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [GAP_W-1:0] gap_len = '0;
    logic cmd_valid, cmd_rsp_exp;
    logic [5:0]  cmd_idx;
    logic [31:0] cmd_arg;
    logic cmd_done = 1'b0, st_sent = 1'b0, st_rsp_end = 1'b0;
    logic st_crc_bad = 1'b0, st_timeout = 1'b0;
    logic [31:0] rsp_word = '0;
    logic done, err, high_cap, high_cap_conf;
    logic [31:0] ocr_word;

    always #2 clk = ~clk;

    card_init_seq #(.GAP_W(GAP_W), .MIN_GAP(MIN_GAP), .MAX_TRIES(MAX_TRIES)) u_card_init_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .gap_len(gap_len),
        .cmd_valid(cmd_valid), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .cmd_rsp_exp(cmd_rsp_exp), .cmd_done(cmd_done), .st_sent(st_sent),
        .st_rsp_end(st_rsp_end), .st_crc_bad(st_crc_bad), .st_timeout(st_timeout),
        .rsp_word(rsp_word), .done(done), .err(err), .high_cap(high_cap),
        .high_cap_conf(high_cap_conf), .ocr_word(ocr_word)
    );

    typedef struct {
        int          idx;
        logic [31:0] arg;
        bit          rsp;
    } exp_cmd_t;

    exp_cmd_t exp_q[$];
    int n_vec = 0;
    int n_bad = 0;

    // scenario knobs read by the responder
    int sc_rst_ok = 1, sc_probe = 0, sc_ready_at = 0, sc_app_bad_at = -1;
    int sc_app_kind = 1, sc_opc_to_at = -1, sc_hc30 = 0, sc_crc = 0;
    int sc_lat = 3, exp_gap = MIN_GAP;
    int app_n = 0, opc_n = 0, lat_cnt = 3, low_cnt = 0, last_idx = -1;
    bit prev_valid = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic string tag_of(input int idx);
        case (idx)
            0:  return "R3 reset cmd";
            8:  return "R4 probe cmd";
            55: return "R5 app cmd";
            default: return "R6 opcond cmd";
        endcase
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // monitor (scoreboard pop) and responder model, one negedge process
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_valid = 1'b0;
            lat_cnt    = sc_lat;
        end else begin
            if (cmd_valid && (!prev_valid || cmd_done)) begin
                if (exp_q.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL R2 unexpected command: actual %0d expected none", cmd_idx);
                end else begin
                    exp_cmd_t e;
                    e = exp_q.pop_front();
                    chk({tag_of(e.idx), " index"}, 32'(cmd_idx), 32'(e.idx));
                    chk({tag_of(e.idx), " argument"}, cmd_arg, e.arg);
                    chk({tag_of(e.idx), " response flag"}, 32'(cmd_rsp_exp), 32'(e.rsp));
                end
                if (cmd_idx == 6'd55 && last_idx == 41)
                    chk("R9 quiet gap length", 32'(low_cnt), 32'(exp_gap));
                last_idx = cmd_idx;
                low_cnt  = 0;
            end
            if (!cmd_valid) low_cnt++;
            prev_valid = cmd_valid;

            if (cmd_done) begin
                cmd_done = 1'b0; st_sent = 1'b0; st_rsp_end = 1'b0;
                st_crc_bad = 1'b0; st_timeout = 1'b0; rsp_word = '0;
                lat_cnt = sc_lat;
            end else if (!cmd_valid) begin
                lat_cnt = sc_lat;
            end else if (lat_cnt > 0) begin
                lat_cnt--;
            end else begin
                cmd_done = 1'b1;
                case (cmd_idx)
                    6'd0: begin
                        if (sc_rst_ok != 0) st_sent = 1'b1; else st_timeout = 1'b1;
                    end
                    6'd8: begin
                        if (sc_probe == 1) st_timeout = 1'b1;
                        else begin
                            st_rsp_end = 1'b1;
                            rsp_word = (sc_probe == 0) ? 32'h0000_31AA : 32'h0000_01A5;
                        end
                    end
                    6'd55: begin
                        if (app_n == sc_app_bad_at && sc_app_kind == 2) st_timeout = 1'b1;
                        else begin
                            if (sc_crc != 0) st_crc_bad = 1'b1; else st_rsp_end = 1'b1;
                            rsp_word = (app_n == sc_app_bad_at) ? 32'h0000_0100 : 32'h0000_0120;
                        end
                        app_n++;
                    end
                    default: begin
                        if (opc_n == sc_opc_to_at) st_timeout = 1'b1;
                        else begin
                            if (sc_crc != 0) st_crc_bad = 1'b1; else st_rsp_end = 1'b1;
                            rsp_word = (opc_n >= sc_ready_at)
                                ? (32'h80FF_8000 | (sc_hc30 != 0 ? 32'h4000_0000 : 32'h0))
                                : 32'h00FF_8000;
                        end
                        opc_n++;
                    end
                endcase
            end
        end
    end

    // driver: build the expected command list and outcome, then run
    task automatic run_case(input string name, input int rst_ok, input int probe,
                            input int ready_at, input int app_bad_at, input int app_kind,
                            input int opc_to_at, input int hc30, input int crc,
                            input int glen, input int mid_start);
        bit e_err, e_done, e_hc;
        logic [31:0] e_ocr;
        int waited;
        e_err = 0; e_done = 0; e_hc = 0; e_ocr = '0;
        @(negedge clk);
        sc_rst_ok = rst_ok; sc_probe = probe; sc_ready_at = ready_at;
        sc_app_bad_at = app_bad_at; sc_app_kind = app_kind; sc_opc_to_at = opc_to_at;
        sc_hc30 = hc30; sc_crc = crc; app_n = 0; opc_n = 0;
        gap_len = GAP_W'(glen);
        exp_gap = (glen < MIN_GAP) ? MIN_GAP : glen;

        exp_q.push_back('{0, 32'h0, 1'b0});
        if (rst_ok == 0) e_err = 1;
        else begin
            exp_q.push_back('{8, 32'h0000_01AA, 1'b1});
            e_hc = (probe == 0);
            for (int i = 0; i < 64; i++) begin
                exp_q.push_back('{55, 32'h0, 1'b1});
                if (i == app_bad_at) begin e_err = 1; break; end
                exp_q.push_back('{41, e_hc ? 32'h40FF_8000 : 32'h0080_0000, 1'b1});
                if (i == opc_to_at) begin e_err = 1; break; end
                if (i >= ready_at) begin
                    e_done = 1;
                    e_ocr = 32'h80FF_8000 | (hc30 != 0 ? 32'h4000_0000 : 32'h0);
                    break;
                end
                if (i + 1 == MAX_TRIES) begin e_err = 1; break; end
            end
        end

        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({"R11 cleared on start (done) ", name}, 32'(done), 32'h0);
        chk({"R11 cleared on start (ocr) ", name}, ocr_word, 32'h0);
        if (mid_start != 0) begin
            repeat (mid_start) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!(done || err) && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        repeat (3) @(negedge clk);
        chk({"R2 all commands issued ", name}, 32'(exp_q.size()), 32'h0);
        exp_q.delete();
        chk({"R8 done ", name}, 32'(done), 32'(e_done));
        chk({"R10 err ", name}, 32'(err), 32'(e_err));
        if (!e_err) begin
            chk({"R4 high_cap ", name}, 32'(high_cap), 32'(e_hc));
            chk({"R8 ocr_word ", name}, ocr_word, e_ocr);
            chk({"R8 high_cap_conf ", name}, 32'(high_cap_conf), 32'(hc30 != 0));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset cmd_valid", 32'(cmd_valid), 32'h0);
        chk("R1 reset done", 32'(done), 32'h0);
        chk("R1 reset err", 32'(err), 32'h0);
        repeat (10) @(negedge clk);
        chk("R1 idle without start", 32'(cmd_valid), 32'h0);

        //       name            rst probe rdy appbad kind opcto hc30 crc glen mid
        run_case("hc_card",       1,  0,   2,  -1,    1,   -1,   1,   0,  5,   0);
        run_case("std_timeout",   1,  1,   0,  -1,    1,   -1,   0,   0,  5,   0);
        run_case("echo_mismatch", 1,  2,   1,  -1,    1,   -1,   0,   0,  33,  0);
        run_case("R3_reset_fail", 0,  0,   0,  -1,    1,   -1,   0,   0,  5,   0);
        run_case("R5_app_bit5",   1,  0,   3,   1,    1,   -1,   0,   0,  5,   0);
        run_case("R5_app_tmo",    1,  1,   3,   0,    2,   -1,   0,   0,  5,   0);
        run_case("R7_opc_tmo",    1,  0,   3,  -1,    1,    0,   0,   0,  5,   0);
        run_case("R7_crc_ok",     1,  0,   1,  -1,    1,   -1,   0,   1,  5,   0);
        run_case("R10_exhaust",   1,  1, 100,  -1,    1,   -1,   0,   0,  5,   0);
        run_case("R1_busy_start", 1,  0,   2,  -1,    1,   -1,   1,   0,  5,  30);

        report();
        $finish;
    end

endmodule